// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block is the digital control side of an eight-input analog-to-digital converter. A CPU reaches it over a small register bus. The bus carries one 8-bit control/status register, a start register and eight result registers. The block drives an abstract converter through a start pulse and a channel number. It waits for the converter's busy/done handshake and stores each 10-bit result in the register that belongs to that channel.

Three modes are available: one conversion on a single channel, a scan through an aligned group of four channels, and a scan through all eight. A scan covers the channels from the lowest one in its group up to the selected channel, in ascending order. It repeats until software clears the start bit.

A sticky end flag marks the end of work. In single mode it rises after the one conversion. In a scan it rises only after the last channel of the group. Hardware can set the flag and software cannot. Software clears it by writing 0 after it has read the flag as 1. A DMA-style data read clears it too, unless that read holds its keep-flag input high. The interrupt output is the flag gated by the enable bit.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the status register at address 0 reads 0x08, and the start register at address 1 reads 0.
- R2: Bit 3 of the status register always reads 1, whatever value is written to it.
- R3: With mode 00 (bits 5:4) and start written to 1 (bit 0 of address 1), exactly one conversion runs, on the channel in bits 2:0. The flag (bit 7) sets when that conversion completes, and the start bit then reads 0.
- R4: With mode 01, the channels from the selected channel with its two low bits cleared up to the selected channel are converted in ascending order. The flag sets only after the last of them.
- R5: With mode 10, channels 0 up to the selected channel are converted in ascending order. The flag sets only after the last of them.
- R6: A scan restarts from its first channel while start stays 1. After start is cleared, the conversion in flight finishes and no further conversion starts.
- R7: A CPU write of 1 to bit 7 never sets the flag.
- R8: Writing 0 to bit 7 clears the flag only if the flag was read as 1 at address 0 since it was last set. A write without that read leaves the flag at 1.
- R9: A DMA read (dma_rd) with dma_keep at 0 clears the flag. With dma_keep at 1 the flag stays at 1. Both return the result of channel dma_ch.
- R10: irq equals the flag ANDed with the interrupt enable in bit 6.
- R11: While start is 1, writes to the mode and channel fields are ignored, and the enable bit still takes the written value.
- R12: With mode 11 no conversion is started, even when start is 1.
- R13: Each result is stored as 10 bits and reads back, zero-extended, at address 8 plus the channel number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 4 | Register address: 0 status, 1 start, 8 to 15 results |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; it arms the flag clear |
| wdata | input | 8 | Write data |
| rdata | output | 16 | Read data, combinational from addr |
| conv_start | output | 1 | One-cycle request to the converter |
| conv_ch | output | 3 | Channel number for the request |
| conv_busy | input | 1 | Converter is busy; requests wait |
| conv_done | input | 1 | One-cycle pulse: conv_result is valid |
| conv_result | input | 10 | Converted value |
| dma_rd | input | 1 | DMA-style result read strobe |
| dma_ch | input | 3 | Channel read by the DMA |
| dma_keep | input | 1 | When 1, the DMA read leaves the flag set |
| dma_rdata | output | 10 | Result of channel dma_ch |
| irq | output | 1 | Conversion-end interrupt |

## Verification
- **Register writes:** a write becomes visible on rdata one cycle after the clock edge that takes it. The bench drives each write across a single rising edge and reads at the following falling edge.
- **Conversion timing:** conv_start rises in the second cycle after the start write. A stored result and the flag change at the edge that samples conv_done.
- **Converter model:** the bench's converter raises done a fixed number of cycles after each request and logs the channel of every request. The bench then polls the flag at falling edges, within a bound. When the flag is first seen, the log length shows that no earlier group end set it.
- **Stop and ignored writes:** checks that something stops or is ignored wait a fixed window longer than one conversion before reading back the log or the register.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int CH_W = 3;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_SCAN4  = 2'b01,
    MODE_SCAN8  = 2'b10,
    MODE_BAD    = 2'b11
  } adc_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } seq_state_e;

  // first channel converted for a given mode and selected channel
  function automatic logic [CH_W-1:0] first_chan(adc_mode_e m, logic [CH_W-1:0] sel);
    case (m)
      MODE_SCAN4: return {sel[CH_W-1], 2'b00};
      MODE_SCAN8: return '0;
      default:    return sel;
    endcase
  endfunction

  function automatic logic mode_runs(adc_mode_e m);
    return m != MODE_BAD;
  endfunction

  // status register image: flag, enable, mode, fixed one, channel
  function automatic logic [7:0] pack_status(logic flag, logic ie, adc_mode_e m,
                                             logic [CH_W-1:0] ch);
    return {flag, ie, m, 1'b1, ch};
  endfunction
endpackage

// File: rtl/adc_csr_regs.sv
module adc_csr_regs
  import adc_seq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            csr_wr,
  input  logic            csr_rd,
  input  logic            ctrl_wr,
  input  logic [7:0]      wdata,
  input  logic            flag_set_evt,
  input  logic            start_clr,
  input  logic            dma_clr_evt,
  output logic            flag_q,
  output logic            ie_q,
  output adc_mode_e       mode_q,
  output logic [CH_W-1:0] ch_q,
  output logic            start_q,
  output logic            armed_q,
  output logic            sw_clr_evt,
  output logic [7:0]      status_val
);
  logic unused_fixed_bit;
  assign unused_fixed_bit = wdata[3];

  assign sw_clr_evt = csr_wr && !wdata[7] && armed_q && flag_q;
  assign status_val = pack_status(flag_q, ie_q, mode_q, ch_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (flag_set_evt)                   flag_q <= 1'b1;
      else if (sw_clr_evt || dma_clr_evt) flag_q <= 1'b0;

      if (flag_set_evt || csr_wr || !flag_q) armed_q <= 1'b0;
      else if (csr_rd)                       armed_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie_q   <= 1'b0;
      mode_q <= MODE_SINGLE;
      ch_q   <= '0;
    end else if (csr_wr) begin
      ie_q <= wdata[6];
      if (!start_q) begin
        mode_q <= adc_mode_e'(wdata[5:4]);
        ch_q   <= wdata[CH_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       start_q <= 1'b0;
    else if (start_clr) start_q <= 1'b0;
    else if (ctrl_wr) start_q <= wdata[0];
  end
endmodule

// File: rtl/adc_scan_fsm.sv
module adc_scan_fsm
  import adc_seq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_q,
  input  adc_mode_e       mode_q,
  input  logic [CH_W-1:0] sel_ch,
  input  logic            conv_busy,
  input  logic            conv_done,
  output logic            conv_start,
  output logic [CH_W-1:0] conv_ch,
  output logic            store_evt,
  output logic            group_done_evt,
  output logic            start_clr,
  output logic [CH_W-1:0] run_ch
);
  seq_state_e      state_q;
  adc_mode_e       run_mode_q;
  logic [CH_W-1:0] cur_q;
  logic [CH_W-1:0] last_q;
  logic            at_last;

  assign at_last        = (cur_q == last_q);
  assign conv_start     = (state_q == ST_ISSUE) && start_q && !conv_busy;
  assign conv_ch        = cur_q;
  assign run_ch         = last_q;
  assign store_evt      = (state_q == ST_WAIT) && conv_done;
  assign group_done_evt = store_evt && at_last;
  assign start_clr      = group_done_evt && (run_mode_q == MODE_SINGLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      run_mode_q <= MODE_SINGLE;
      cur_q      <= '0;
      last_q     <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_q && mode_runs(mode_q)) begin
            run_mode_q <= mode_q;
            last_q     <= sel_ch;
            cur_q      <= first_chan(mode_q, sel_ch);
            state_q    <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (!start_q)        state_q <= ST_IDLE;
          else if (!conv_busy) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (conv_done) begin
            if (run_mode_q == MODE_SINGLE || !start_q) begin
              state_q <= ST_IDLE;
            end else begin
              cur_q   <= at_last ? first_chan(run_mode_q, last_q) : cur_q + 1'b1;
              state_q <= ST_ISSUE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int RES_W  = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             store_evt,
  input  logic [CH_W-1:0]  store_ch,
  input  logic [RES_W-1:0] store_val,
  input  logic [CH_W-1:0]  cpu_idx,
  input  logic [CH_W-1:0]  dma_idx,
  output logic [RES_W-1:0] cpu_val,
  output logic [RES_W-1:0] dma_val
);
  logic [RES_W-1:0] res_q [NUM_CH];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    always_ff @(posedge clk) begin
      if (!rst_n)                                        res_q[i] <= '0;
      else if (store_evt && (store_ch == CH_W'(i)))      res_q[i] <= store_val;
    end
  end

  assign cpu_val = res_q[cpu_idx];
  assign dma_val = res_q[dma_idx];
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int RES_W  = 10,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [7:0]        wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              conv_start,
  output logic [CH_W-1:0]   conv_ch,
  input  logic              conv_busy,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_result,
  input  logic              dma_rd,
  input  logic [CH_W-1:0]   dma_ch,
  input  logic              dma_keep,
  output logic [RES_W-1:0]  dma_rdata,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] STATUS_ADDR = '0;
  localparam logic [ADDR_W-1:0] START_ADDR  = ADDR_W'(1);

  logic status_hit, start_hit, data_hit;
  logic flag_q, ie_q, start_q, armed_q, sw_clr_evt;
  logic flag_set_evt, dma_clr_evt, store_evt, start_clr;
  adc_mode_e       mode_q;
  logic [CH_W-1:0] ch_q, run_ch;
  logic [7:0]      status_val;
  logic [RES_W-1:0] cpu_res;

  assign status_hit  = (addr == STATUS_ADDR);
  assign start_hit   = (addr == START_ADDR);
  assign data_hit    = addr[ADDR_W-1];
  assign dma_clr_evt = dma_rd && !dma_keep && flag_q;
  assign irq         = flag_q && ie_q;

  adc_csr_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .csr_wr(wr_en && status_hit), .csr_rd(rd_en && status_hit),
    .ctrl_wr(wr_en && start_hit), .wdata(wdata),
    .flag_set_evt(flag_set_evt), .start_clr(start_clr), .dma_clr_evt(dma_clr_evt),
    .flag_q(flag_q), .ie_q(ie_q), .mode_q(mode_q), .ch_q(ch_q),
    .start_q(start_q), .armed_q(armed_q), .sw_clr_evt(sw_clr_evt),
    .status_val(status_val)
  );

  adc_scan_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start_q(start_q), .mode_q(mode_q), .sel_ch(ch_q),
    .conv_busy(conv_busy), .conv_done(conv_done),
    .conv_start(conv_start), .conv_ch(conv_ch), .store_evt(store_evt),
    .group_done_evt(flag_set_evt), .start_clr(start_clr), .run_ch(run_ch)
  );

  adc_result_bank #(.NUM_CH(NUM_CH), .RES_W(RES_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .store_evt(store_evt), .store_ch(conv_ch),
    .store_val(conv_result), .cpu_idx(addr[CH_W-1:0]), .dma_idx(dma_ch),
    .cpu_val(cpu_res), .dma_val(dma_rdata)
  );

  always_comb begin
    rdata = '0;
    if (status_hit)     rdata[7:0]       = status_val;
    else if (start_hit) rdata[0]         = start_q;
    else if (data_hit)  rdata[RES_W-1:0] = cpu_res;
  end
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flag_q,
  input logic              armed_q,
  input logic              flag_set_evt,
  input logic              dma_clr_evt,
  input logic              dma_rd,
  input logic              dma_keep,
  input logic [1:0]        mode_q,
  input logic              start_q,
  input logic              conv_start,
  input logic [2:0]        conv_ch,
  input logic [2:0]        run_ch,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rdata,
  input logic              irq
);
  AST_FLAG_ONLY_HW_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_q && !flag_set_evt) |=> !flag_q); // R7
  AST_FLAG_CLEAR_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !armed_q && !dma_clr_evt) |=> flag_q); // R8
  AST_DMA_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && dma_rd && !dma_keep && !flag_set_evt) |=> !flag_q); // R9
  AST_IRQ_AT_PORTS: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == '0) |-> (irq == (rdata[7] && rdata[6]))); // R10
  AST_FIXED_BIT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == '0) |-> rdata[3]); // R2
  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> $stable(mode_q)); // R11
  AST_NO_START_BAD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b11) |-> !conv_start); // R12
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start); // R3
  AST_CHAN_IN_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> (conv_ch <= run_ch)); // R4
endmodule

bind adc_seq_ctrl adc_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flag_q(flag_q), .armed_q(armed_q),
  .flag_set_evt(flag_set_evt), .dma_clr_evt(dma_clr_evt), .dma_rd(dma_rd),
  .dma_keep(dma_keep), .mode_q(mode_q), .start_q(start_q), .conv_start(conv_start),
  .conv_ch(conv_ch), .run_ch(run_ch), .addr(addr), .rdata(rdata), .irq(irq)
);

// File: tb/tb_adc_seq_ctrl.sv
module tb_adc_seq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  wdata = '0;
  logic [15:0] rdata;
  logic        conv_start;
  logic [2:0]  conv_ch;
  logic        conv_busy = 1'b0, conv_done = 1'b0;
  logic [9:0]  conv_result = '0;
  logic        dma_rd = 1'b0, dma_keep = 1'b0;
  logic [2:0]  dma_ch = '0;
  logic [9:0]  dma_rdata;
  logic        irq;

  int checks = 0, errors = 0;
  int log_ch [64];
  int log_n = 0, total = 0, busy_cnt = 0;
  int exp_res [8];
  logic [9:0] pend = '0;

  always #5 clk = ~clk;

  adc_seq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .conv_start(conv_start), .conv_ch(conv_ch),
    .conv_busy(conv_busy), .conv_done(conv_done), .conv_result(conv_result),
    .dma_rd(dma_rd), .dma_ch(dma_ch), .dma_keep(dma_keep), .dma_rdata(dma_rdata),
    .irq(irq)
  );

  function automatic int model_res(int ch, int n);
    return (ch * 131 + n * 37 + 5) % 1024;
  endfunction

  // converter model: done three cycles after a request
  always @(posedge clk) begin
    conv_done <= 1'b0;
    if (!rst_n) begin
      busy_cnt = 0;
      conv_busy <= 1'b0;
    end else if (busy_cnt != 0) begin
      if (busy_cnt == 1) begin
        conv_done   <= 1'b1;
        conv_result <= pend;
        conv_busy   <= 1'b0;
      end
      busy_cnt = busy_cnt - 1;
    end else if (conv_start) begin
      if (log_n < 64) log_ch[log_n] = int'(conv_ch);
      log_n = log_n + 1;
      pend = 10'(model_res(int'(conv_ch), total));
      exp_res[conv_ch] = model_res(int'(conv_ch), total);
      total = total + 1;
      busy_cnt = 3;
      conv_busy <= 1'b1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic cpu_read(input logic [3:0] a, output int v);
    @(negedge clk); addr = a; rd_en = 1'b1; #1 v = int'(rdata);
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic peek(input logic [3:0] a, output int v);
    addr = a; #1 v = int'(rdata);
  endtask

  task automatic dma_read(input logic [2:0] ch, input logic keep, output int v);
    @(negedge clk); dma_ch = ch; dma_keep = keep; dma_rd = 1'b1; #1 v = int'(dma_rdata);
    @(negedge clk); dma_rd = 1'b0;
  endtask

  task automatic wait_flag(input string req, output int n_at_flag);
    int v;
    n_at_flag = -1;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      peek(4'd0, v);
      if (v[7]) begin n_at_flag = log_n; break; end
    end
    if (n_at_flag < 0) chk({req, " flag timeout"}, 0, 1);
  endtask

  initial begin
    int v, n0, n1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset values
    peek(4'd0, v); chk("R1 status reset", v, 8'h08);
    peek(4'd1, v); chk("R1 start reset", v, 0);

    // fixed bit and software set attempt
    cpu_write(4'd0, 8'h00); peek(4'd0, v); chk("R2 bit3 reads one", v, 8'h08);
    cpu_write(4'd0, 8'h80); peek(4'd0, v); chk("R7 flag not set by write", v & 8'h80, 0);

    // single mode, channel 5, enable on
    log_n = 0;
    cpu_write(4'd0, 8'h45);
    cpu_write(4'd1, 8'h01);
    wait_flag("R3", n0);
    chk("R3 one conversion", n0, 1);
    chk("R3 channel", log_ch[0], 5);
    repeat (10) @(negedge clk);
    chk("R3 no further conversion", log_n, 1);
    peek(4'd1, v); chk("R3 start self-clears", v, 0);
    peek(4'd13, v); chk("R13 result ch5", v, exp_res[5]);
    chk("R10 irq with enable", int'(irq), 1);

    // clear protocol
    cpu_write(4'd0, 8'h45); peek(4'd0, v); chk("R8 write0 without read keeps flag", v[7], 1);
    cpu_read(4'd0, v); chk("R8 read sees flag", v[7], 1);
    cpu_write(4'd0, 8'h45); peek(4'd0, v); chk("R8 clear after read", v[7], 0);
    chk("R10 irq low after clear", int'(irq), 0);

    // single mode, channel 2, enable off; DMA clear
    cpu_write(4'd0, 8'h02);
    cpu_write(4'd1, 8'h01);
    wait_flag("R3", n0);
    chk("R10 irq gated by enable", int'(irq), 0);
    dma_read(3'd2, 1'b1, v); chk("R9 dma data", v, exp_res[2]);
    peek(4'd0, v); chk("R9 keep leaves flag", v[7], 1);
    dma_read(3'd2, 1'b0, v); chk("R13 dma data ch2", v, exp_res[2]);
    peek(4'd0, v); chk("R9 dma clears flag", v[7], 0);

    // four-channel scan ending at channel 6
    log_n = 0;
    cpu_write(4'd0, 8'h16);
    cpu_write(4'd1, 8'h01);
    cpu_write(4'd0, 8'h63);
    peek(4'd0, v); chk("R11 fields frozen, enable written", v & 8'h7F, 8'h5E);
    wait_flag("R4", n0);
    chk("R4 flag after whole group", n0, 3);
    for (int i = 0; i < 3; i++) chk("R4 ascending order", log_ch[i], 4 + i);
    for (int i = 4; i < 7; i++) begin peek(4'(8 + i), v); chk("R13 scan result", v, exp_res[i]); end
    cpu_read(4'd0, v);
    cpu_write(4'd0, 8'h56);
    wait_flag("R6", n0);
    chk("R6 second pass count", n0, 6);
    chk("R6 restarts at group base", log_ch[3], 4);
    cpu_write(4'd1, 8'h00);
    repeat (20) @(negedge clk);
    n1 = log_n;
    repeat (30) @(negedge clk);
    chk("R6 stops after clear", log_n, n1);

    // eight-channel scan ending at channel 2
    cpu_read(4'd0, v);
    cpu_write(4'd0, 8'h22);
    peek(4'd0, v); chk("R8 clear with mode change", v, 8'h2A);
    log_n = 0;
    cpu_write(4'd1, 8'h01);
    wait_flag("R5", n0);
    chk("R5 flag after whole group", n0, 3);
    for (int i = 0; i < 3; i++) chk("R5 ascending order", log_ch[i], i);
    cpu_write(4'd1, 8'h00);
    repeat (30) @(negedge clk);

    // prohibited mode
    cpu_read(4'd0, v);
    cpu_write(4'd0, 8'h30);
    log_n = 0;
    cpu_write(4'd1, 8'h01);
    repeat (40) @(negedge clk);
    chk("R12 no conversion", log_n, 0);
    peek(4'd0, v); chk("R12 flag stays clear", v[7], 0);
    cpu_write(4'd1, 8'h00);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule